// File: doc/BRIEF.md
# Scrolling Seven-Segment Message Controller

This block moves the fixed text "CPEN 311" across a row of six seven-segment digits. The text enters at the rightmost digit and travels left one character per scroll tick until it has left the row completely. It then starts again from an empty row. The scroll tick is a single-cycle enable that the surrounding logic derives from a slower time base.

A row of ten LEDs counts the passes. Each finished pass moves a single lit LED one place higher. Once ten passes are done, the LED row stops counting and blinks as a whole, in step with the scroll ticks, until the block is reset. The text keeps scrolling while the LEDs blink.

The block has three parts. A Moore controller holds the scroll position, the pass count and the mode. A bank of six registered digits turns the current position into segment patterns. An LED driver updates the loop indicator.

Top module: `scroll_msg_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge every digit output becomes 7'h7F (all segments off), `led` becomes all zeros and the scroll position returns to its first value. This happens whatever `step` is doing.
- R2: On a cycle where `step` is low, the scroll position and `led` keep their values, and the digit outputs stop changing one cycle later.
- R3: Digits are numbered with `seg5` leftmost and `seg0` rightmost. The character stream is six blanks, then C, P, E, N, space, 3, 1, 1, then blanks from there on. When the position is p, digit k shows stream entry p+5-k. A `step` pulse advances p by one at its clock edge, and the digits show the new window one clock later.
- R4: Segment buses are active-low with bit order {g,f,e,d,c,b,a}. The patterns are: C = 7'h46, P = 7'h0C, E = 7'h06, N = 7'h48, 3 = 7'h30, 1 = 7'h79. Space and blank are both 7'h7F. One tick after reset, `seg0` shows 7'h46.
- R5: A pass is 14 ticks long (positions 0 to 13). The tick taken at position 13 returns the position to 0, which is an all-blank row, and the same sequence then repeats.
- R6: Before the first pass completes, `led` is all zeros. After completed pass n (1 to 10), exactly bit n-1 is lit and all other bits are off.
- R7: The tick that completes the tenth pass both lights bit 9 and enters flicker mode. In flicker mode, each tick sets `led` to all ones if it was not all ones, and to all zeros if it was. Flicker mode lasts until reset, and scrolling continues during it.
- R8: A reset applied in the middle of a run, even on a cycle where `step` is high, clears the pass count and the flicker mode. The next tick after that behaves as the first tick of a fresh run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Scroll tick enable, one cycle per advance |
| seg0 | output | 7 | Rightmost digit, active-low {g,f,e,d,c,b,a} |
| seg1 | output | 7 | Digit 1 |
| seg2 | output | 7 | Digit 2 |
| seg3 | output | 7 | Digit 3 |
| seg4 | output | 7 | Digit 4 |
| seg5 | output | 7 | Leftmost digit |
| led | output | 10 | Loop indicator, active high |

## Verification
The scroll wrap and the LED update always happen on the same tick: the tick taken at position 13 returns the row to blank and moves the lit LED. On the tenth such tick, entry into flicker mode is added to that same edge. The bench reaches these coincidences with randomly spaced ticks and also with back-to-back ticks. At every cycle it compares all six digits and the LED row against a reference model built from the requirements. It also checks literal values directly after the first pass and at the first flicker step. A separate case asserts reset together with a tick, to confirm that reset takes priority on that edge.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    localparam int MSG_LEN = 8;
    localparam logic [6:0] SEG_BLANK = 7'h7F;

    typedef enum logic [2:0] {
        CH_SP, CH_C, CH_P, CH_E, CH_N, CH_3, CH_1
    } char_e;

    typedef enum logic {
        MODE_COUNT,
        MODE_FLICKER
    } mode_e;

    typedef struct packed {
        logic  wrap;
        mode_e mode;
    } ctrl_flags_t;

    function automatic char_e msg_char(input int unsigned i);
        case (i)
            0:       return CH_C;
            1:       return CH_P;
            2:       return CH_E;
            3:       return CH_N;
            4:       return CH_SP;
            5:       return CH_3;
            6:       return CH_1;
            7:       return CH_1;
            default: return CH_SP;
        endcase
    endfunction

    function automatic char_e stream_char(input int unsigned idx, input int unsigned lead);
        if (idx < lead || idx >= lead + MSG_LEN)
            return CH_SP;
        return msg_char(idx - lead);
    endfunction

    // active-low, bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] glyph(input char_e c);
        case (c)
            CH_C:    return 7'h46;
            CH_P:    return 7'h0C;
            CH_E:    return 7'h06;
            CH_N:    return 7'h48;
            CH_3:    return 7'h30;
            CH_1:    return 7'h79;
            default: return SEG_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/scroll_fsm.sv
module scroll_fsm
    import scroll_pkg::*;
#(
    parameter int N_DIGITS = 6,
    parameter int PASSES   = 10,
    localparam int STREAM_LEN = N_DIGITS + MSG_LEN,
    localparam int POS_W      = $clog2(STREAM_LEN),
    localparam int CNT_W      = $clog2(PASSES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output ctrl_flags_t      flags
);

    localparam logic [POS_W-1:0] LAST = POS_W'(STREAM_LEN - 1);
    localparam logic [CNT_W-1:0] FINAL_PASS = CNT_W'(PASSES - 1);

    mode_e            state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] pass_q, pass_d;
    logic             at_end;

    assign at_end = (pos_q == LAST);

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        pass_d  = pass_q;
        if (step) begin
            pos_d = at_end ? '0 : pos_q + 1'b1;
            if (at_end && state_q == MODE_COUNT) begin
                pass_d = pass_q + 1'b1;
                if (pass_q == FINAL_PASS)
                    state_d = MODE_FLICKER;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_COUNT;
            pos_q   <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            pass_q  <= pass_d;
        end
    end

    // Moore outputs: functions of registered state only
    assign pos        = pos_q;
    assign flags.wrap = at_end;
    assign flags.mode = state_q;

endmodule

// File: rtl/digit_bank.sv
module digit_bank
    import scroll_pkg::*;
#(
    parameter int N_DIGITS = 6,
    parameter int POS_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [POS_W-1:0]           pos,
    output logic [N_DIGITS-1:0][6:0]   seg
);

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_digit
        localparam int unsigned OFFS = N_DIGITS - 1 - k;
        logic [6:0] seg_q;

        always_ff @(posedge clk) begin
            if (rst)
                seg_q <= SEG_BLANK;
            else
                seg_q <= glyph(stream_char(32'(pos) + OFFS, N_DIGITS));
        end

        assign seg[k] = seg_q;
    end

endmodule

// File: rtl/loop_led_driver.sv
module loop_led_driver
    import scroll_pkg::*;
#(
    parameter int N_LEDS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  ctrl_flags_t       flags,
    output logic [N_LEDS-1:0] led
);

    logic [N_LEDS-1:0] led_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= '0;
        end else if (step) begin
            if (flags.mode == MODE_FLICKER)
                led_q <= (&led_q) ? '0 : '1;
            else if (flags.wrap)
                led_q <= (led_q == '0) ? N_LEDS'(1) : (led_q << 1);
        end
    end

    assign led = led_q;

endmodule

// File: rtl/scroll_msg_ctrl.sv
module scroll_msg_ctrl
    import scroll_pkg::*;
#(
    parameter int N_LEDS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [6:0]        seg0,
    output logic [6:0]        seg1,
    output logic [6:0]        seg2,
    output logic [6:0]        seg3,
    output logic [6:0]        seg4,
    output logic [6:0]        seg5,
    output logic [N_LEDS-1:0] led
);

    localparam int N_DIGITS   = 6;
    localparam int STREAM_LEN = N_DIGITS + MSG_LEN;
    localparam int POS_W      = $clog2(STREAM_LEN);

    logic [POS_W-1:0]         pos_q;
    ctrl_flags_t              flags_q;
    logic [N_DIGITS-1:0][6:0] seg_q;

    scroll_fsm #(.N_DIGITS(N_DIGITS), .PASSES(N_LEDS)) u_fsm (
        .clk(clk), .rst(rst), .step(step), .pos(pos_q), .flags(flags_q)
    );

    digit_bank #(.N_DIGITS(N_DIGITS), .POS_W(POS_W)) u_digits (
        .clk(clk), .rst(rst), .pos(pos_q), .seg(seg_q)
    );

    loop_led_driver #(.N_LEDS(N_LEDS)) u_leds (
        .clk(clk), .rst(rst), .step(step), .flags(flags_q), .led(led)
    );

    assign seg0 = seg_q[0];
    assign seg1 = seg_q[1];
    assign seg2 = seg_q[2];
    assign seg3 = seg_q[3];
    assign seg4 = seg_q[4];
    assign seg5 = seg_q[5];

endmodule

// File: rtl/scroll_msg_chk.sv
module scroll_msg_chk
    import scroll_pkg::*;
#(
    parameter int N_LEDS = 10,
    parameter int POS_W  = 4,
    parameter int LAST   = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              step,
    input logic [N_LEDS-1:0] led,
    input logic [POS_W-1:0]  pos_q,
    input ctrl_flags_t       flags_q,
    input logic [6:0]        seg0,
    input logic [6:0]        seg5
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (led == '0 && pos_q == '0 && seg0 == SEG_BLANK && seg5 == SEG_BLANK));

    a_r2_hold_state: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(led) && $stable(pos_q)));

    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q != POS_W'(LAST)) |=> (pos_q == $past(pos_q) + 1'b1));

    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q == POS_W'(LAST)) |=> (pos_q == '0));

    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        (flags_q.mode == MODE_COUNT) |-> $onehot0(led));

    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (flags_q.mode == MODE_FLICKER && step) |=> (led != $past(led)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.mode == MODE_FLICKER) |=> (flags_q.mode == MODE_FLICKER));

endmodule

bind scroll_msg_ctrl scroll_msg_chk #(
    .N_LEDS(N_LEDS), .POS_W(POS_W), .LAST(STREAM_LEN - 1)
) u_chk (
    .clk(clk), .rst(rst), .step(step), .led(led),
    .pos_q(pos_q), .flags_q(flags_q), .seg0(seg0), .seg5(seg5)
);

// File: tb/test_scroll_msg_ctrl.sv
module test_scroll_msg_ctrl;

    logic clk = 1'b0;
    logic rst, step;
    logic [6:0] s0, s1, s2, s3, s4, s5;
    logic [9:0] led;

    always #4 clk = ~clk;   // 125 MHz

    scroll_msg_ctrl i_scroll_msg_ctrl (
        .clk(clk), .rst(rst), .step(step),
        .seg0(s0), .seg1(s1), .seg2(s2), .seg3(s3), .seg4(s4), .seg5(s5),
        .led(led)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    string phase = "R1";

    // reference model state, built from the requirements
    int   m_pos, m_pass;
    bit   m_flick;
    logic [9:0] m_led;
    logic [6:0] m_seg [6];

    function automatic logic [6:0] ref_seg(input int idx);
        if (idx < 6 || idx >= 14) return 7'h7F;
        case (idx - 6)
            0: return 7'h46;  // C
            1: return 7'h0C;  // P
            2: return 7'h06;  // E
            3: return 7'h48;  // N
            5: return 7'h30;  // 3
            6, 7: return 7'h79; // 1
            default: return 7'h7F;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_pass = 0; m_flick = 0; m_led = '0;
            for (int k = 0; k < 6; k++) m_seg[k] = 7'h7F;
        end else begin
            for (int k = 0; k < 6; k++) m_seg[k] = ref_seg(m_pos + 5 - k);
            if (step) begin
                if (m_flick) m_led = (m_led == 10'h3FF) ? 10'h000 : 10'h3FF;
                else if (m_pos == 13) begin
                    m_led = (m_led == 0) ? 10'd1 : (m_led << 1);
                    m_pass++;
                    if (m_pass == 10) m_flick = 1;
                end
                m_pos = (m_pos == 13) ? 0 : m_pos + 1;
            end
        end
    end

    task automatic check_all(input string req);
        logic [51:0] act, exp;
        act = {s5, s4, s3, s2, s1, s0, led};
        exp = {m_seg[5], m_seg[4], m_seg[3], m_seg[2], m_seg[1], m_seg[0], m_led};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle at a negedge, then check at the following negedge
    task automatic cycle_with(input logic s);
        step = s;
        @(posedge clk);
        @(negedge clk);
        check_all(phase);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst = 1'b1; step = 1'b0;
        @(negedge clk);
        phase = "R1";
        cycle_with(1'b0);
        cycle_with(1'b1);                      // R1: step during reset ignored
        check_val("R1", {6'd0, led}, 16'd0);
        rst = 1'b0;

        // R4: first tick brings C into the rightmost digit
        phase = "R3";
        cycle_with(1'b1);
        cycle_with(1'b0);
        check_val("R4", {9'd0, s0}, 16'h0046);
        cycle_with(1'b1);
        cycle_with(1'b1);
        cycle_with(1'b0);

        // R2: holding with a non-blank row
        phase = "R2";
        for (int i = 0; i < 6; i++) cycle_with(1'b0);

        // R5: rest of first pass back-to-back (ticks 4..14)
        phase = "R5";
        for (int i = 0; i < 11; i++) cycle_with(1'b1);
        cycle_with(1'b0);
        check_val("R5", {9'd0, s5}, 16'h007F);
        check_val("R6", {6'd0, led}, 16'h0001);

        // R6: random tick spacing until ten passes complete
        phase = "R6";
        while (m_pass < 10) cycle_with(1'(($urandom % 2) == 0));
        cycle_with(1'b0);
        check_val("R7", {6'd0, led}, 16'h0200);

        // R7: flicker mode with random ticks
        phase = "R7";
        cycle_with(1'b1);
        check_val("R7", {6'd0, led}, 16'h03FF);
        for (int i = 0; i < 80; i++) cycle_with(1'(($urandom % 3) != 0));

        // R8: reset coinciding with a tick, then fresh run
        phase = "R8";
        rst = 1'b1;
        cycle_with(1'b1);
        rst = 1'b0;
        check_val("R8", {6'd0, led}, 16'd0);
        for (int i = 0; i < 20; i++) cycle_with(1'b1);
        check_val("R8", {6'd0, led}, 16'h0001);
        for (int i = 0; i < 30; i++) cycle_with(1'(($urandom % 2) == 0));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule